// File: doc/BRIEF.md
# Programmable Rate Divider with Square-Wave and Periodic Flag

The block divides a 32.768 kHz timebase into one of thirteen binary rates chosen by a 4-bit rate code. One divider chain drives two outputs. The first is a square wave with a 50% duty cycle. The second is a sticky periodic flag that is set once per full period. Each output has its own enable. The square-wave enable forces the pin low. The interrupt enable only gates the interrupt request; the flag itself keeps running.

The timebase arrives as a single-cycle `tick` enable in the system clock domain, and only cycles with `tick` high advance the divider. A status-read strobe clears the flag. When a period ends in the same cycle as that strobe, the set wins. Writing a new rate code restarts the divider, so the first period after the change has its full length. All pins are plain control and status levels; the block has no streaming data path, so no valid/ready handshake exists at its edge.

Top module: `prd_rate_top`

## Requirements
- R1: While reset is asserted and immediately after it, `sqw`, `pf` and `irq` are 0.
- R2: For rate codes 3 to 15, `pf` sets after exactly 2^(code-1) ticks counted from a rate change, and not earlier. It is set on the clock edge that samples the final tick.
- R3: Rate code 1 gives the same period as code 8 (128 ticks), and rate code 2 gives the same period as code 9 (256 ticks).
- R4: Rate code 0 stops the divider. No tick sets `pf`, and `sqw` stays 0.
- R5: After a rate change the square-wave level is 0 for the first half-period, 2^(code-2) ticks, and 1 for the second half. The level changes on the same edges that end each half-period, and each full period ends with the level returning to 0.
- R6: With `sqw_en` = 0, `sqw` is 0. The hidden phase keeps running, so raising `sqw_en` shows the current phase at once.
- R7: `irq` equals `pf` AND `pie` with no added delay. `pie` has no effect on when `pf` sets.
- R8: A `flag_clr` pulse clears `pf` on the next edge. If a period ends in the same cycle as the clear, `pf` stays 1.
- R9: Changing `rate_sel` restarts the divider. The tick in the cycle of the change is ignored, and the next period counts its full length from the following tick.
- R10: Cycles with `tick` = 0 do not advance the divider. Sparse ticks give the same tick counts as back-to-back ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase enable at 32.768 kHz |
| rate_sel | input | 4 | Rate code (0 off, 1/2 aliases, 3..15 binary rates) |
| sqw_en | input | 1 | Square-wave output enable |
| pie | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Status-read strobe that clears the periodic flag |
| sqw | output | 1 | Square-wave output |
| pf | output | 1 | Sticky periodic flag |
| irq | output | 1 | Interrupt request, `pf` gated by `pie` |

## Verification
The assertions assume that `tick` is synchronous to `clk` and lasts one cycle, and that `rate_sel` is a stable registered level between deliberate writes. Under these assumptions every difference between `rate_sel` and the held code is an intended restart. The stimulus drives all inputs on the falling edge. It changes `rate_sel` only in isolated cycles, and it generates ticks either back to back or at a fixed gap.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int RS_W      = 4;
  localparam int MAX_CODE  = (1 << RS_W) - 1;
  localparam int CNT_W     = MAX_CODE - 2;
  localparam int MIN_CODE  = 3;
  localparam int ALIAS_LO  = 8;
  localparam int ALIAS_HI  = 9;

  typedef logic [RS_W-1:0]  rate_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // Map alias codes onto their binary-rate equivalents.
  function automatic rate_t effective_code(input rate_t rs);
    rate_t r;
    case (rs)
      rate_t'(1): r = rate_t'(ALIAS_LO);
      rate_t'(2): r = rate_t'(ALIAS_HI);
      default:    r = rs;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/prd_rate_decode.sv
module prd_rate_decode
  import prd_pkg::*;
(
  input  rate_t rate_q,
  output logic  active,
  output cnt_t  half_last
);
  rate_t eff;
  int    sh;

  always_comb begin
    eff       = effective_code(rate_q);
    active    = (rate_q != '0);
    sh        = (int'(eff) >= MIN_CODE) ? int'(eff) - 2 : 0;
    half_last = active ? (cnt_t'(1) << sh) - cnt_t'(1) : '0;
  end
endmodule

// File: rtl/prd_divider.sv
module prd_divider
  import prd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  rate_t rate_sel,
  input  logic  active,
  input  cnt_t  half_last,
  output rate_t rate_q,
  output logic  phase,
  output logic  period_end
);
  cnt_t cnt;
  logic change;
  logic half_wrap;

  assign change     = (rate_sel != rate_q);
  assign half_wrap  = tick && !change && active && (cnt == half_last);
  assign period_end = half_wrap && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      cnt    <= '0;
      phase  <= 1'b0;
    end else if (change) begin
      rate_q <= rate_sel;
      cnt    <= '0;
      phase  <= 1'b0;
    end else if (tick && active) begin
      if (cnt == half_last) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + cnt_t'(1);
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= half_last); // R2

  AST_CHANGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    change |=> (cnt == '0) && !phase); // R9

  AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !change) |=> $stable(phase) && $stable(cnt)); // R10

  AST_OFF_NO_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0 && !change) |=> !phase); // R4
endmodule

// File: rtl/prd_flag.sv
module prd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic period_end,
  input  logic flag_clr,
  output logic pf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pf <= 1'b0;
    else        pf <= period_end | (pf & ~flag_clr);
  end

  AST_PF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> pf); // R8

  AST_PF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !period_end) |=> !pf); // R8

  AST_PF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (pf && !flag_clr) |=> pf); // R8
endmodule

// File: rtl/prd_rate_top.sv
module prd_rate_top
  import prd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [RS_W-1:0] rate_sel,
  input  logic            sqw_en,
  input  logic            pie,
  input  logic            flag_clr,
  output logic            sqw,
  output logic            pf,
  output logic            irq
);
  rate_t rate_q;
  logic  active;
  cnt_t  half_last;
  logic  phase;
  logic  period_end;

  prd_rate_decode u_dec (
    .rate_q    (rate_q),
    .active    (active),
    .half_last (half_last)
  );

  prd_divider u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .rate_sel   (rate_sel),
    .active     (active),
    .half_last  (half_last),
    .rate_q     (rate_q),
    .phase      (phase),
    .period_end (period_end)
  );

  prd_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .flag_clr   (flag_clr),
    .pf         (pf)
  );

  assign sqw = sqw_en & phase;
  assign irq = pf & pie;

  AST_PF_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pf) |-> $past(tick)); // R10

  AST_SQW_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sqw) && $stable(sqw_en)) |-> $past(tick)); // R5
endmodule

// File: tb/sim_prd_rate_top.sv
module sim_prd_rate_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [3:0] rate_sel = 4'd0;
  logic       sqw_en = 1'b1;
  logic       pie = 1'b0;
  logic       flag_clr = 1'b0;
  logic       sqw, pf, irq;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prd_rate_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .sqw_en(sqw_en), .pie(pie), .flag_clr(flag_clr),
    .sqw(sqw), .pf(pf), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int rs);
    int e;
    e = (rs == 1) ? 8 : (rs == 2) ? 9 : rs;
    return 1 << (e - 1);
  endfunction

  // Write a new rate code and clear the flag in the same cycle.
  task automatic set_rate(input int rs, input bit tick_in_change);
    @(negedge clk);
    rate_sel = 4'(rs);
    tick     = tick_in_change;
    flag_clr = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    flag_clr = 1'b0;
    tick     = 1'b0;
  endtask

  // Apply one tick after (gap-1) idle cycles; check outputs after its edge.
  task automatic one_tick(input int gap);
    for (int i = 1; i < gap; i++) begin
      @(negedge clk); tick = 1'b0;
      @(posedge clk);
    end
    @(negedge clk); tick = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic run_rate(input int rs, input int gap, input bit ie);
    int p, h, bad_pf, bad_sqw, bad_irq;
    string tag;
    p = period_of(rs);
    h = p / 2;
    bad_pf = 0; bad_sqw = 0; bad_irq = 0;
    tag = (gap > 1) ? "R10" : (rs < 3) ? "R3" : "R2";
    pie = ie;
    set_rate(rs, 1'b1);                            // R9: tick in change cycle ignored
    chk("R9 pf cleared on change", int'(pf), 0);
    for (int n = 1; n <= p; n++) begin
      one_tick(gap);
      if (int'(pf) != ((n == p) ? 1 : 0)) bad_pf++;
      if (int'(sqw) != (((n / h) % 2 == 1) ? 1 : 0)) bad_sqw++;
      if (irq !== (pf & ie)) bad_irq++;
    end
    chk({tag, " pf period mismatches"}, bad_pf, 0);
    chk("R5 sqw half-period mismatches", bad_sqw, 0);
    chk("R7 irq gating mismatches", bad_irq, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 sqw in reset", int'(sqw), 0);
    chk("R1 pf in reset", int'(pf), 0);
    chk("R1 irq in reset", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 pf after reset", int'(pf), 0);

    // Full sweep of every nonzero code with back-to-back ticks.
    for (int rs = 1; rs < 16; rs++) run_rate(rs, 1, rs[0]);
    // Sparse ticks on fast codes.
    for (int rs = 3; rs <= 8; rs++) run_rate(rs, 3, 1'b1);

    // R4: code 0 stops everything.
    set_rate(0, 1'b0);
    begin
      int seen;
      seen = 0;
      for (int n = 0; n < 40; n++) begin
        one_tick(1);
        if (pf !== 1'b0 || sqw !== 1'b0) seen++;
      end
      chk("R4 code 0 activity", seen, 0);
    end

    // R6: enable off hides the phase, which keeps running.
    sqw_en = 1'b0;
    set_rate(5, 1'b0);                             // period 16, half 8
    for (int n = 0; n < 10; n++) one_tick(1);
    chk("R6 sqw held low", int'(sqw), 0);
    @(negedge clk); sqw_en = 1'b1; #1;
    chk("R6 phase visible on enable", int'(sqw), 1);

    // R7: pie does not affect pf; irq follows pie combinationally.
    @(negedge clk); pie = 1'b0;
    for (int n = 0; n < 6; n++) one_tick(1);
    chk("R7 pf set with pie low", int'(pf), 1);
    chk("R7 irq low with pie low", int'(irq), 0);
    @(negedge clk); pie = 1'b1; #1;
    chk("R7 irq follows pie", int'(irq), 1);

    // R8: plain clear, then collision of clear with a period end.
    @(negedge clk); flag_clr = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear", int'(pf), 0);
    @(negedge clk); flag_clr = 1'b0;
    set_rate(3, 1'b0);                             // period 4
    for (int n = 0; n < 3; n++) one_tick(1);
    chk("R8 not yet set", int'(pf), 0);
    @(negedge clk); tick = 1'b1; flag_clr = 1'b1;
    @(posedge clk); #1;
    chk("R8 set wins over clear", int'(pf), 1);
    @(negedge clk); tick = 1'b0;
    @(posedge clk); #1;
    chk("R8 clear next cycle", int'(pf), 0);
    @(negedge clk); flag_clr = 1'b0;

    // R9: change mid-period restarts with full length.
    set_rate(4, 1'b0);                             // period 8
    for (int n = 0; n < 5; n++) one_tick(1);
    set_rate(5, 1'b1);                             // period 16, tick ignored
    chk("R9 sqw low after change", int'(sqw), 0);
    for (int n = 0; n < 15; n++) one_tick(1);
    chk("R9 no early flag", int'(pf), 0);
    chk("R9 sqw high in second half", int'(sqw), 1);
    one_tick(1);
    chk("R9 full period after change", int'(pf), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule